// File: doc/BRIEF.md
# Staggered SDRAM Refresh Scheduler

This block decides when a group of SDRAM devices behind one memory controller gets its auto-refresh. A free-running interval counter marks the end of each refresh period and raises a request. The request first waits politely for a moment when the controller has no other work queued. If that moment does not come within two further periods, the request escalates. It then takes the controller as soon as the operation in flight ends.

When the scheduler wins the controller it fires one refresh strobe per device, one device per clock, lowest index first. This spreads the supply current over several cycles instead of drawing it in one. Each device that has just been refreshed is then fenced off from activates for a programmable number of clocks. The period and recovery length come from configuration inputs. They are only taken in while the scheduler has nothing pending. A combinational flag warns when the period setting does not exceed the recovery setting.

Top module: `refresh_sched`

## Requirements
- R1: With a sampled period of P clocks, the interval counter expires every P clocks, and the request output `ref_req` rises in the cycle after each expiry. The first request after reset is visible P cycles after reset is released.
- R2: A request that has not escalated is granted (`ref_grant` high) only in a cycle where `ctrl_busy` is low and `other_pending` is low. Otherwise it keeps waiting.
- R3: If a request stays ungranted while the counter expires two more times, `ref_hi` goes high in the cycle after the second of those expiries.
- R4: An escalated request is granted in the first cycle where `ctrl_busy` is low, even with `other_pending` high. It is never granted while `ctrl_busy` is high.
- R5: Bit d of `dev_ref` is the strobe for device d. After a grant in cycle G, `dev_ref[d]` is high in cycle G+1+d only, so at most one strobe is high per cycle.
- R6: With a sampled recovery count R, `act_block[d]` is high for exactly the R cycles following the cycle in which `dev_ref[d]` was high. With R = 0 it stays low.
- R7: `cfg_bad` is high exactly when `cfg_interval` is less than or equal to `cfg_recovery`.
- R8: `cfg_interval` and `cfg_recovery` are taken in only while no request is pending and no refresh sequence is running. Changes made while a request waits do not alter that request's timing or its lockout length.
- R9: The count of missed expiries is zero once a refresh sequence has run. The next request therefore starts at low priority.
- R10: `sched_busy` is high from the grant cycle through the cycle of the last device's strobe, and low otherwise.
- R11: A synchronous active-high `rst` clears the request, the escalation, the sequence, the interval counter and all lockouts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_interval | input | TW | Refresh period in clocks |
| cfg_recovery | input | RW | Activate lockout length in clocks after a refresh |
| ctrl_busy | input | 1 | Controller is executing an operation |
| other_pending | input | 1 | Other memory requests are queued at the controller |
| ref_req | output | 1 | Refresh request outstanding |
| ref_hi | output | 1 | Outstanding request has escalated |
| ref_grant | output | 1 | Scheduler takes the controller this cycle |
| sched_busy | output | 1 | Grant or refresh sequence in progress |
| dev_ref | output | NDEV | Per-device auto-refresh strobes |
| act_block | output | NDEV | Per-device activate lockout |
| cfg_bad | output | 1 | Period does not exceed recovery |

## Verification
The bench holds `other_pending` high to push a request through both missed expiries. A design that escalated one period early or late would show `ref_hi` and the grant in the wrong cycle. The bench also holds `ctrl_busy` across escalation, which catches a design that lets a high-priority request barge into a running operation. It changes the configuration while a request waits, which exposes a design that reloads its period or recovery mid-request. It also covers a zero recovery count and a reset in the middle of a sequence, where an off-by-one lockout or a surviving counter would show up at the per-device outputs.

// File: rtl/refresh_pkg.sv
package refresh_pkg;

  // Number of further expiries a waiting request tolerates before escalating.
  localparam int unsigned ESCALATE_AFTER = 2;

  // True in the last cycle of a period of 'per' clocks (per of 0 or 1 fires every cycle).
  function automatic logic period_done(input logic [31:0] cnt, input logic [31:0] per);
    return (cnt + 32'd1) >= per;
  endfunction

  // A period must be strictly longer than the recovery window.
  function automatic logic cfg_consistent(input logic [31:0] per, input logic [31:0] rec);
    return per > rec;
  endfunction

endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [TW-1:0] period,
  output logic          expire
);
  import refresh_pkg::*;

  logic [TW-1:0] cnt_q;

  assign expire = period_done(32'(cnt_q), 32'(period));

  always_ff @(posedge clk) begin
    if (rst || expire) cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/refresh_prio.sv
module refresh_prio (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic ctrl_busy,
  input  logic other_pending,
  input  logic seq_active,
  output logic req,
  output logic hi,
  output logic grant
);
  import refresh_pkg::*;

  localparam int MW = $clog2(ESCALATE_AFTER + 1);
  localparam logic [MW-1:0] MISS_TOP = MW'(ESCALATE_AFTER);

  logic          req_q;
  logic [MW-1:0] miss_q;

  assign req   = req_q;
  assign hi    = req_q && (miss_q == MISS_TOP);
  assign grant = req_q && !seq_active && !ctrl_busy && (hi || !other_pending);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q  <= 1'b0;
      miss_q <= '0;
    end else if (grant) begin
      req_q  <= expire;
      miss_q <= '0;
    end else if (expire) begin
      if (!req_q) begin
        req_q  <= 1'b1;
        miss_q <= '0;
      end else if (miss_q != MISS_TOP) begin
        miss_q <= miss_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/refresh_stagger.sv
module refresh_stagger #(
  parameter int NDEV = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  output logic [NDEV-1:0] dev_ref,
  output logic            active
);
  localparam int IW = (NDEV > 1) ? $clog2(NDEV) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(NDEV - 1);

  logic          active_q;
  logic [IW-1:0] idx_q;
  logic          last;

  assign active = active_q;
  assign last   = active_q && (idx_q == LAST_IDX);

  for (genvar g = 0; g < NDEV; g++) begin : g_strobe
    assign dev_ref[g] = active_q && (idx_q == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q) begin
      active_q <= !last;
      idx_q    <= last ? '0 : idx_q + 1'b1;
    end
  end
endmodule

// File: rtl/refresh_lockout.sv
module refresh_lockout #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fire,
  input  logic [RW-1:0] recovery,
  output logic          blocked
);
  logic [RW-1:0] cnt_q;

  assign blocked = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (fire)    cnt_q <= recovery;
    else if (blocked) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int NDEV = 4,
  parameter int TW   = 16,
  parameter int RW   = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [TW-1:0]   cfg_interval,
  input  logic [RW-1:0]   cfg_recovery,
  input  logic            ctrl_busy,
  input  logic            other_pending,
  output logic            ref_req,
  output logic            ref_hi,
  output logic            ref_grant,
  output logic            sched_busy,
  output logic [NDEV-1:0] dev_ref,
  output logic [NDEV-1:0] act_block,
  output logic            cfg_bad
);
  import refresh_pkg::*;

  logic [TW-1:0] per_q;
  logic [RW-1:0] rec_q;
  logic          idle;
  logic          tmr_expire;
  logic          seq_active;

  assign idle       = !ref_req && !seq_active;
  assign sched_busy = ref_grant || seq_active;
  assign cfg_bad    = !cfg_consistent(32'(cfg_interval), 32'(cfg_recovery));

  always_ff @(posedge clk) begin
    if (rst || idle) begin
      per_q <= cfg_interval;
      rec_q <= cfg_recovery;
    end
  end

  refresh_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .period (per_q),
    .expire (tmr_expire)
  );

  refresh_prio u_prio (
    .clk           (clk),
    .rst           (rst),
    .expire        (tmr_expire),
    .ctrl_busy     (ctrl_busy),
    .other_pending (other_pending),
    .seq_active    (seq_active),
    .req           (ref_req),
    .hi            (ref_hi),
    .grant         (ref_grant)
  );

  refresh_stagger #(.NDEV(NDEV)) u_stagger (
    .clk     (clk),
    .rst     (rst),
    .start   (ref_grant),
    .dev_ref (dev_ref),
    .active  (seq_active)
  );

  for (genvar d = 0; d < NDEV; d++) begin : g_lock
    refresh_lockout #(.RW(RW)) u_lock (
      .clk      (clk),
      .rst      (rst),
      .fire     (dev_ref[d]),
      .recovery (rec_q),
      .blocked  (act_block[d])
    );
  end
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int NDEV = 4,
  parameter int RW   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            ctrl_busy,
  input logic            other_pending,
  input logic            ref_req,
  input logic            ref_hi,
  input logic            ref_grant,
  input logic            sched_busy,
  input logic [NDEV-1:0] dev_ref,
  input logic [NDEV-1:0] act_block,
  input logic            tmr_expire,
  input logic            seq_active,
  input logic [RW-1:0]   rec_q
);
  a_r1_expire_raises: assert property (@(posedge clk) disable iff (rst)
    tmr_expire |=> ref_req);

  a_r2_low_needs_quiet: assert property (@(posedge clk) disable iff (rst)
    (ref_grant && !ref_hi) |-> !other_pending);

  a_r3_hi_has_req: assert property (@(posedge clk) disable iff (rst)
    ref_hi |-> ref_req);

  a_r4_no_grant_busy: assert property (@(posedge clk) disable iff (rst)
    ref_grant |-> !ctrl_busy);

  a_r4_hi_served: assert property (@(posedge clk) disable iff (rst)
    (ref_hi && !ctrl_busy && !seq_active) |-> ref_grant);

  a_r5_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_ref));

  a_r5_first_dev: assert property (@(posedge clk) disable iff (rst)
    ref_grant |=> dev_ref[0]);

  a_r10_busy_cover: assert property (@(posedge clk) disable iff (rst)
    (ref_grant || (|dev_ref)) |-> sched_busy);

  for (genvar g = 0; g < NDEV; g++) begin : g_dev
    if (g < NDEV - 1) begin : g_chain
      a_r5_next_dev: assert property (@(posedge clk) disable iff (rst)
        dev_ref[g] |=> dev_ref[g+1]);
    end
    a_r6_lock_starts: assert property (@(posedge clk) disable iff (rst)
      (dev_ref[g] && (rec_q != '0)) |=> act_block[g]);
  end
endmodule

bind refresh_sched refresh_sched_chk #(.NDEV(NDEV), .RW(RW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .ctrl_busy     (ctrl_busy),
  .other_pending (other_pending),
  .ref_req       (ref_req),
  .ref_hi        (ref_hi),
  .ref_grant     (ref_grant),
  .sched_busy    (sched_busy),
  .dev_ref       (dev_ref),
  .act_block     (act_block),
  .tmr_expire    (tmr_expire),
  .seq_active    (seq_active),
  .rec_q         (rec_q)
);

// File: tb/refresh_sched_bench.sv
`timescale 1ns/1ps
module refresh_sched_bench;
  localparam int ND = 4;
  localparam int TW = 16;
  localparam int RW = 8;

  localparam int TBL_N = 4;
  localparam int TBL_P [TBL_N] = '{20, 12, 30, 16};
  localparam int TBL_R [TBL_N] = '{3, 0, 10, 1};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] cfg_interval = '0;
  logic [RW-1:0] cfg_recovery = '0;
  logic          ctrl_busy = 1'b0;
  logic          other_pending = 1'b0;
  logic          ref_req, ref_hi, ref_grant, sched_busy, cfg_bad;
  logic [ND-1:0] dev_ref, act_block;

  int n = 0;
  int ntot = 0;
  int nfail = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  refresh_sched #(.NDEV(ND), .TW(TW), .RW(RW)) u_refresh_sched (
    .clk (clk), .rst (rst), .cfg_interval (cfg_interval), .cfg_recovery (cfg_recovery),
    .ctrl_busy (ctrl_busy), .other_pending (other_pending), .ref_req (ref_req),
    .ref_hi (ref_hi), .ref_grant (ref_grant), .sched_busy (sched_busy),
    .dev_ref (dev_ref), .act_block (act_block), .cfg_bad (cfg_bad)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      ntot++; nfail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("%0d/%0d checks passed", ntot - nfail, ntot);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
    ntot++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: got %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    n++;
  endtask

  task automatic step_to(input int t);
    while (n < t) step();
  endtask

  task automatic do_reset(input int p, input int r);
    rst = 1'b1;
    cfg_interval = TW'(p);
    cfg_recovery = RW'(r);
    ctrl_busy = 1'b0;
    other_pending = 1'b0;
    step();
    step();
    rst = 1'b0;
    n = 0;
  endtask

  function automatic logic [ND-1:0] exp_ref(input int w, input int p);
    for (int k = 0; k < ND; k++) exp_ref[k] = (w == p + 1 + k);
  endfunction

  function automatic logic [ND-1:0] exp_blk(input int w, input int p, input int r);
    for (int k = 0; k < ND; k++) exp_blk[k] = (w >= p + 2 + k) && (w <= p + 1 + k + r);
  endfunction

  initial begin
    // R11: outputs quiet out of reset
    do_reset(10, 2);
    chk(!ref_req && !ref_hi && !ref_grant, "R11", "request after reset", int'(ref_req), 0);
    chk(dev_ref == '0 && act_block == '0 && !sched_busy, "R11", "strobes after reset",
        int'(dev_ref | act_block), 0);

    // Table walk: uncontended refresh per configuration (R1 R2 R5 R6 R10)
    for (int s = 0; s < TBL_N; s++) begin
      int p;
      int r;
      int e_req, e_gnt, e_ref, e_blk, e_bsy;
      p = TBL_P[s];
      r = TBL_R[s];
      e_req = 0; e_gnt = 0; e_ref = 0; e_blk = 0; e_bsy = 0;
      do_reset(p, r);
      for (int w = 1; w <= p + ND + r + 3; w++) begin
        step();
        if (ref_req !== (w == p) || ref_hi !== 1'b0) e_req++;
        if (ref_grant !== (w == p)) e_gnt++;
        if (dev_ref !== exp_ref(w, p)) begin
          e_ref++;
          $display("  window %0d dev_ref=%b wanted %b", w, dev_ref, exp_ref(w, p));
        end
        if (act_block !== exp_blk(w, p, r)) begin
          e_blk++;
          $display("  window %0d act_block=%b wanted %b", w, act_block, exp_blk(w, p, r));
        end
        if (sched_busy !== (w >= p && w <= p + ND)) e_bsy++;
      end
      chk(e_req == 0, "R1", "request timing mismatches", e_req, 0);
      chk(e_gnt == 0, "R2", "grant timing mismatches", e_gnt, 0);
      chk(e_ref == 0, "R5", "stagger mismatches", e_ref, 0);
      chk(e_blk == 0, "R6", "lockout mismatches", e_blk, 0);
      chk(e_bsy == 0, "R10", "busy window mismatches", e_bsy, 0);
    end

    // Escalation under constant pending traffic (R2 R3 R4 R9)
    do_reset(10, 2);
    other_pending = 1'b1;
    step_to(10);
    chk(ref_req == 1'b1, "R1", "request at first expiry", int'(ref_req), 1);
    chk(ref_grant == 1'b0, "R2", "low request held off by pending", int'(ref_grant), 0);
    step_to(29);
    chk(ref_hi == 1'b0, "R3", "not escalated before second miss", int'(ref_hi), 0);
    step_to(30);
    chk(ref_hi == 1'b1, "R3", "escalated after second miss", int'(ref_hi), 1);
    chk(ref_grant == 1'b1, "R4", "high request granted despite pending", int'(ref_grant), 1);
    step_to(31);
    chk(dev_ref == 4'b0001, "R5", "first strobe after escalated grant", int'(dev_ref), 1);
    step_to(40);
    chk(ref_req == 1'b1 && ref_hi == 1'b0, "R9", "next request starts low",
        int'({ref_req, ref_hi}), 2);

    // High request waits for the running operation (R4)
    do_reset(10, 2);
    other_pending = 1'b1;
    ctrl_busy = 1'b1;
    step_to(30);
    chk(ref_hi == 1'b1 && ref_grant == 1'b0, "R4", "no grant while controller busy",
        int'({ref_hi, ref_grant}), 2);
    step_to(33);
    ctrl_busy = 1'b0;
    #1;
    chk(ref_grant == 1'b1, "R4", "grant once operation ends", int'(ref_grant), 1);
    step_to(34);
    chk(dev_ref == 4'b0001, "R5", "device 0 strobe", int'(dev_ref), 1);
    step_to(37);
    chk(dev_ref == 4'b1000, "R5", "last device strobe", int'(dev_ref), 8);

    // Low request: busy alone blocks it, then pending drops (R2)
    do_reset(10, 2);
    ctrl_busy = 1'b1;
    step_to(10);
    chk(ref_grant == 1'b0, "R2", "low request held off by busy", int'(ref_grant), 0);
    ctrl_busy = 1'b0;
    other_pending = 1'b1;
    step_to(15);
    chk(ref_grant == 1'b0, "R2", "still held by pending", int'(ref_grant), 0);
    other_pending = 1'b0;
    #1;
    chk(ref_grant == 1'b1, "R2", "granted when pending clears", int'(ref_grant), 1);

    // Configuration changes while a request waits are ignored (R8)
    do_reset(10, 2);
    other_pending = 1'b1;
    step_to(12);
    cfg_interval = TW'(50);
    cfg_recovery = RW'(7);
    step_to(30);
    chk(ref_grant == 1'b1, "R8", "old period kept while pending", int'(ref_grant), 1);
    step_to(33);
    chk(act_block[0] == 1'b1, "R8", "device 0 lockout last cycle", int'(act_block[0]), 1);
    step_to(34);
    chk(act_block[0] == 1'b0, "R8", "device 0 lockout uses old length", int'(act_block[0]), 0);

    // Period versus recovery consistency flag (R7)
    cfg_interval = TW'(5); cfg_recovery = RW'(5); #1;
    chk(cfg_bad == 1'b1, "R7", "equal settings flagged", int'(cfg_bad), 1);
    cfg_interval = TW'(6); #1;
    chk(cfg_bad == 1'b0, "R7", "longer period accepted", int'(cfg_bad), 0);
    cfg_interval = TW'(4); cfg_recovery = RW'(9); #1;
    chk(cfg_bad == 1'b1, "R7", "shorter period flagged", int'(cfg_bad), 1);

    // Reset in the middle of a sequence (R11)
    do_reset(10, 5);
    step_to(12);
    rst = 1'b1;
    step();
    chk(dev_ref == '0 && act_block == '0 && !sched_busy && !ref_req, "R11",
        "mid-sequence reset clears", int'(dev_ref | act_block), 0);
    rst = 1'b0;
    n = 0;
    step_to(9);
    chk(ref_req == 1'b0, "R11", "timer restarted from zero", int'(ref_req), 0);
    step_to(10);
    chk(ref_req == 1'b1, "R11", "request one period after reset", int'(ref_req), 1);

    $display("%0d/%0d checks passed", ntot - nfail, ntot);
    $finish;
  end
endmodule